// File: doc/BRIEF.md
# Dual-Protocol Control Port Register File

This block is the slave side of a chip's configuration port. An external controller reaches a small bank of byte-wide registers through a two-wire I2C link or a four-wire SPI link. The same physical pins serve both protocols. Every register drives its contents to the rest of the chip on `cfg_o`. One register holds a fixed identification byte that a controller can read but cannot change.

After reset the port runs as I2C. In this mode the shared `cs_ni` pin supplies the low bit of the slave address. The first falling edge on that pin switches the port to SPI, and it stays in SPI until the next reset. From then on the pin acts as an active-low chip select. In both protocols the byte after the device address loads an address pointer. Bit 7 of that byte turns auto-increment on, and bits 4:0 select the register. Auto-increment runs through two separate address sections, and the pointer never crosses from one section into the other.

All pins are brought into the block clock domain through two-stage synchronisers. Every protocol event is then decoded from sampled edges. For this reason the block clock must run well above the serial clock.

Top module: `ctl_port_regs`

## Requirements
- R1: After reset, every configuration register reads 00h, the pointer is 00h with auto-increment off, the port is in I2C mode, `sda_oe_o` is 0 and `sdo_o` is 0.
- R2: In I2C mode the port acknowledges only the 7-bit slave address {001100, `cs_ni`}. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R3: In both protocols the byte after the device address loads the pointer: bit 7 is the auto-increment flag and bits 4:0 are the register address. Data bytes then write the register at the pointer, and each data byte is acknowledged in I2C.
- R4: With auto-increment off, the pointer stays fixed across successive data bytes, so the last byte written wins.
- R5: With auto-increment on, the pointer advances by one after each byte that is read or written, within 01h..08h and within 09h..11h. It holds at 08h and at 11h and never moves from 08h to 09h. At 00h and at 12h..1Fh it holds.
- R6: An I2C read (R/W bit = 1) returns the register at the current pointer, MSB first. It continues with further bytes while the master acknowledges and stops at a master NACK.
- R7: Address 12h reads A0h: ID code 1010 in bits 7:4 and revision 0000 in bits 3:0. Writes to 12h are acknowledged and have no effect.
- R8: Writes to 00h and to 13h..1Fh are acknowledged and have no effect. Reads from these addresses return 00h.
- R9: The first falling edge on `cs_ni` puts the port permanently into SPI mode. After that, I2C traffic is ignored and `sda_oe_o` is never asserted.
- R10: In SPI mode, a transfer with `cs_ni` low starts with the chip byte {0011000, R/W}. With R/W = 0 the next byte is the pointer byte and the bytes after it are data writes. Data is taken MSB first on rising `scl_i` edges.
- R11: In SPI mode, a chip byte with R/W = 1 makes every following byte a read from the current pointer. The data is shifted out MSB first on `sdo_o`, which changes after falling `scl_i` edges.
- R12: In SPI mode, a transfer whose chip byte does not match changes neither the registers nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock: I2C SCL or SPI clock |
| sda_i | input | 1 | I2C data line as seen on the pad, or SPI data in |
| cs_ni | input | 1 | Slave address bit in I2C mode; active-low chip select in SPI mode |
| sda_oe_o | output | 1 | Pulls the I2C data line low when 1 |
| sdo_o | output | 1 | SPI serial data out |
| cfg_o | output | 136 | Register contents; byte k holds address k+1 (01h..11h) |

## Verification
The hardest state to reach from the ports is the pointer sitting on a section end with auto-increment on, while traffic keeps arriving. The stimulus gets there by writing and reading runs long enough to run past 08h and 11h. Because the protocol switch cannot be undone, all I2C stimulus, directed and random, runs before the first chip-select edge. A single drop of `cs_ni` then starts SPI, and I2C traffic sent after it confirms that the old protocol stays silent.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int unsigned PTR_W = 5;
  localparam int unsigned DATA_W = 8;
  localparam logic [PTR_W-1:0] SEC0_LO = 5'h01;
  localparam logic [PTR_W-1:0] SEC0_HI = 5'h08;
  localparam logic [PTR_W-1:0] SEC1_LO = 5'h09;
  localparam logic [PTR_W-1:0] SEC1_HI = 5'h11;
  localparam logic [PTR_W-1:0] ID_ADDR = 5'h12;
  localparam int unsigned NUM_CFG = int'(SEC1_HI);
  localparam int unsigned CFG_BITS = NUM_CFG * DATA_W;

  // advance only inside a section; both section ends and all other addresses hold
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p, input logic incr);
    if (incr && ((p >= SEC0_LO && p < SEC0_HI) || (p >= SEC1_LO && p < SEC1_HI)))
      return p + 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= {2{RST_VAL[g]}};
      else         st_q <= {st_q[0], d_i[g]};
    end
    assign q_o[g] = st_q[1];
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_port_pkg::*;
#(
  parameter logic [3:0] ID_CODE  = 4'hA,
  parameter logic [3:0] REV_CODE = 4'h0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ptr_ld_i,
  input  logic                wr_en_i,
  input  logic                rd_adv_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             incr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else if (ptr_ld_i) begin
      ptr_q  <= data_i[PTR_W-1:0];
      incr_q <= data_i[DATA_W-1];
    end else if (wr_en_i || rd_adv_i) begin
      ptr_q  <= ptr_next(ptr_q, incr_q);
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (wr_en_i && ptr_q == PTR_W'(g + 1)) r_q <= data_i;
    end
    assign cfg_o[g*DATA_W +: DATA_W] = r_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (ptr_q >= SEC0_LO && ptr_q <= SEC1_HI)
      rd_data_o = cfg_o[DATA_W*(int'(ptr_q)-1) +: DATA_W];
    else if (ptr_q == ID_ADDR)
      rd_data_o = {ID_CODE, REV_CODE};
  end

  // R5
  sec_end_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == SEC0_HI && !ptr_ld_i) |=> (ptr_q == SEC0_HI));
  // R4
  fixed_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!incr_q && !ptr_ld_i) |=> $stable(ptr_q));
  // R8
  ignored_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(ptr_q >= SEC0_LO && ptr_q <= SEC1_HI)) |=> $stable(cfg_o));
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave
  import ctl_port_pkg::*;
#(
  parameter logic [5:0] CHIP_ADDR = 6'b001100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              addr_bit_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              ptr_ld_o,
  output logic              wr_en_o,
  output logic              rd_adv_o,
  output logic [DATA_W-1:0] data_o
);
  typedef enum logic [1:0] {I_IDLE, I_RX, I_TX} phase_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_e;

  phase_e            phase_q;
  kind_e             kind_q;
  logic [3:0]        cnt_q;   // rising edges seen in the 9-clock frame
  logic [DATA_W-1:0] sr_q, tx_q, tx_sh;
  logic              rw_q, oe_q, ptr_ld_q, wr_q, adv_q;

  assign tx_sh = tx_q << cnt_q[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= I_IDLE;  kind_q <= K_ADDR;  cnt_q <= '0;
      sr_q <= '0;  tx_q <= '0;  rw_q <= 1'b0;  oe_q <= 1'b0;
      ptr_ld_q <= 1'b0;  wr_q <= 1'b0;  adv_q <= 1'b0;
    end else begin
      ptr_ld_q <= 1'b0;  wr_q <= 1'b0;  adv_q <= 1'b0;
      if (!en_i) begin
        phase_q <= I_IDLE;  oe_q <= 1'b0;
      end else if (start_i) begin
        phase_q <= I_RX;  kind_q <= K_ADDR;  cnt_q <= '0;  oe_q <= 1'b0;
      end else if (stop_i) begin
        phase_q <= I_IDLE;  oe_q <= 1'b0;
      end else if (phase_q == I_RX) begin
        if (scl_rise_i) begin
          if (cnt_q < 4'd8) sr_q <= {sr_q[DATA_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          unique case (kind_q)
            K_ADDR: begin
              if (sr_q[7:1] == {CHIP_ADDR, addr_bit_i}) begin
                oe_q <= 1'b1;  rw_q <= sr_q[0];
              end else phase_q <= I_IDLE;
            end
            K_PTR:   begin oe_q <= 1'b1;  ptr_ld_q <= 1'b1;  kind_q <= K_DATA; end
            default: begin oe_q <= 1'b1;  wr_q <= 1'b1; end
          endcase
        end else if (scl_fall_i && cnt_q == 4'd9) begin
          cnt_q <= '0;  oe_q <= 1'b0;
          if (kind_q == K_ADDR) begin
            if (rw_q) begin
              phase_q <= I_TX;  tx_q <= rd_data_i;  oe_q <= ~rd_data_i[DATA_W-1];
            end else kind_q <= K_PTR;
          end
        end
      end else if (phase_q == I_TX) begin
        if (scl_rise_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == 4'd8 && sda_i) phase_q <= I_IDLE;  // master NACK
        end else if (scl_fall_i) begin
          if (cnt_q == 4'd8) begin
            oe_q <= 1'b0;  adv_q <= 1'b1;
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;  tx_q <= rd_data_i;  oe_q <= ~rd_data_i[DATA_W-1];
          end else oe_q <= ~tx_sh[DATA_W-1];
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_ld_o = ptr_ld_q;
  assign wr_en_o  = wr_q;
  assign rd_adv_o = adv_q;
  assign data_o   = sr_q;
endmodule

// File: rtl/ctl_spi_slave.sv
module ctl_spi_slave
  import ctl_port_pkg::*;
#(
  parameter logic [5:0] CHIP_ADDR = 6'b001100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              ptr_ld_o,
  output logic              wr_en_o,
  output logic              rd_adv_o,
  output logic [DATA_W-1:0] data_o
);
  logic [2:0]        cnt_q;
  logic [1:0]        idx_q;   // 0 chip byte, 1 second byte, 2 later bytes
  logic [DATA_W-1:0] sr_q, sr_nx, tx_q, tx_sh;
  logic              rw_q, dead_q, sdo_q, ptr_ld_q, wr_q, adv_q;

  assign sr_nx = {sr_q[DATA_W-2:0], mosi_i};
  assign tx_sh = tx_q << cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;  idx_q <= '0;  sr_q <= '0;  tx_q <= '0;
      rw_q <= 1'b0;  dead_q <= 1'b0;  sdo_q <= 1'b0;
      ptr_ld_q <= 1'b0;  wr_q <= 1'b0;  adv_q <= 1'b0;
    end else begin
      ptr_ld_q <= 1'b0;  wr_q <= 1'b0;  adv_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;  idx_q <= '0;  rw_q <= 1'b0;  dead_q <= 1'b0;  sdo_q <= 1'b0;
      end else if (sclk_rise_i) begin
        sr_q  <= sr_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == 3'd7) begin
          if (idx_q != 2'd2) idx_q <= idx_q + 1'b1;
          if (idx_q == 2'd0) begin
            dead_q <= (sr_nx[7:1] != {CHIP_ADDR, 1'b0});
            rw_q   <= sr_nx[0];
          end else if (!dead_q) begin
            if (rw_q)               adv_q    <= 1'b1;
            else if (idx_q == 2'd1) ptr_ld_q <= 1'b1;
            else                    wr_q     <= 1'b1;
          end
        end
      end else if (sclk_fall_i && rw_q && !dead_q && idx_q != 2'd0) begin
        if (cnt_q == 3'd0) begin
          tx_q <= rd_data_i;  sdo_q <= rd_data_i[DATA_W-1];
        end else sdo_q <= tx_sh[DATA_W-1];
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign ptr_ld_o = ptr_ld_q;
  assign wr_en_o  = wr_q;
  assign rd_adv_o = adv_q;
  assign data_o   = sr_q;
endmodule

// File: rtl/ctl_port_regs.sv
module ctl_port_regs
  import ctl_port_pkg::*;
#(
  parameter logic [5:0] CHIP_ADDR = 6'b001100,
  parameter logic [3:0] ID_CODE   = 4'hA,
  parameter logic [3:0] REV_CODE  = 4'h0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                cs_ni,
  output logic                sda_oe_o,
  output logic                sdo_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pin_q, prev_q;
  logic scl_q, sda_q, cs_q, scl_rise, scl_fall, sda_rise, sda_fall, cs_fall;
  logic mode_spi_q;

  ctl_pin_sync #(.W(NPIN), .RST_VAL('1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sda_i, scl_i}),
    .q_o   (pin_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= pin_q;
  end

  assign scl_q    = pin_q[0];
  assign sda_q    = pin_q[1];
  assign cs_q     = pin_q[2];
  assign scl_rise = scl_q & ~prev_q[0];
  assign scl_fall = ~scl_q & prev_q[0];
  assign sda_rise = sda_q & ~prev_q[1];
  assign sda_fall = ~sda_q & prev_q[1];
  assign cs_fall  = ~cs_q & prev_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_spi_q <= 1'b0;
    else if (cs_fall) mode_spi_q <= 1'b1;
  end

  logic              i2c_ld, i2c_wr, i2c_adv, spi_ld, spi_wr, spi_adv;
  logic [DATA_W-1:0] i2c_data, spi_data, rd_data;

  ctl_i2c_slave #(.CHIP_ADDR(CHIP_ADDR)) i_i2c (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (~mode_spi_q),
    .addr_bit_i(cs_q),
    .start_i   (sda_fall & scl_q),
    .stop_i    (sda_rise & scl_q),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_q),
    .rd_data_i (rd_data),
    .sda_oe_o  (sda_oe_o),
    .ptr_ld_o  (i2c_ld),
    .wr_en_o   (i2c_wr),
    .rd_adv_o  (i2c_adv),
    .data_o    (i2c_data)
  );

  ctl_spi_slave #(.CHIP_ADDR(CHIP_ADDR)) i_spi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode_spi_q & ~cs_q),
    .sclk_rise_i(scl_rise),
    .sclk_fall_i(scl_fall),
    .mosi_i     (sda_q),
    .rd_data_i  (rd_data),
    .sdo_o      (sdo_o),
    .ptr_ld_o   (spi_ld),
    .wr_en_o    (spi_wr),
    .rd_adv_o   (spi_adv),
    .data_o     (spi_data)
  );

  ctl_reg_bank #(.ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ptr_ld_i (i2c_ld | spi_ld),
    .wr_en_i  (i2c_wr | spi_wr),
    .rd_adv_i (i2c_adv | spi_adv),
    .data_i   (mode_spi_q ? spi_data : i2c_data),
    .rd_data_o(rd_data),
    .cfg_o    (cfg_o)
  );

  // R9
  spi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_spi_q |=> mode_spi_q);
  // R9
  i2c_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_spi_q |=> !sda_oe_o);
endmodule

// File: tb/test_ctl_port_regs.sv
module test_ctl_port_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 12;          // block clocks per serial half period
  localparam int NCFG = 17;
  localparam logic [7:0] I2C_WR = 8'h32, I2C_RD = 8'h33, I2C_BAD = 8'h30;
  localparam logic [7:0] SPI_WR = 8'h30, SPI_RD = 8'h31, SPI_BAD = 8'h34;

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1, cs_n = 1'b1;
  logic sda_line, sda_oe, sdo;
  logic [NCFG*8-1:0] cfg;

  assign sda_line = sda_m & ~sda_oe;

  ctl_port_regs i_ctl_port_regs (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line), .cs_ni(cs_n),
    .sda_oe_o(sda_oe), .sdo_o(sdo), .cfg_o(cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_err = 0;
  logic [7:0] mdl [0:31];
  logic [4:0] mptr;
  logic       mincr;
  logic [7:0] wbuf [0:15];

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] nxt(input logic [4:0] p, input logic inc);
    if (!inc || p == 5'd8 || p == 5'd17) return p;
    if (p >= 5'd1 && p <= 5'd16) return p + 5'd1;
    return p;
  endfunction

  task automatic mdl_write(input logic [7:0] d);
    if (mptr >= 5'd1 && mptr <= 5'd17) mdl[mptr] = d;
    mptr = nxt(mptr, mincr);
  endtask

  task automatic mdl_read(output logic [7:0] d);
    if (mptr >= 5'd1 && mptr <= 5'd17) d = mdl[mptr];
    else if (mptr == 5'd18) d = 8'hA0;
    else d = 8'h00;
    mptr = nxt(mptr, mincr);
  endtask

  task automatic check_cfg(input string tag);
    for (int i = 0; i < NCFG; i++) chk8(tag, cfg[i*8 +: 8], mdl[i+1]);
  endtask

  // I2C master
  task automatic i2c_start();
    sda_m = 1'b1; wait_clk(HALF); scl = 1'b1; wait_clk(HALF);
    sda_m = 1'b0; wait_clk(HALF); scl = 1'b0; wait_clk(HALF);
  endtask

  task automatic i2c_stop();
    scl = 1'b0; sda_m = 1'b0; wait_clk(HALF); scl = 1'b1; wait_clk(HALF);
    sda_m = 1'b1; wait_clk(2*HALF);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(HALF); scl = 1'b1; wait_clk(HALF); scl = 1'b0;
    end
    sda_m = 1'b1; wait_clk(HALF); scl = 1'b1; wait_clk(HALF/2);
    ack = ~sda_line; wait_clk(HALF/2); scl = 1'b0;
  endtask

  task automatic i2c_rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(HALF); scl = 1'b1; wait_clk(HALF/2); b[i] = sda_line;
      wait_clk(HALF/2); scl = 1'b0;
    end
    sda_m = ~mack; wait_clk(HALF); scl = 1'b1; wait_clk(HALF); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic i2c_write(input logic [7:0] pb, input int nd, input string tag);
    logic ack;
    i2c_start();
    i2c_wbyte(I2C_WR, ack); chk8("R2 address ack", {7'd0, ack}, 8'd1);
    i2c_wbyte(pb, ack);     chk8({tag, " pointer ack"}, {7'd0, ack}, 8'd1);
    mptr = pb[4:0]; mincr = pb[7];
    for (int k = 0; k < nd; k++) begin
      i2c_wbyte(wbuf[k], ack); chk8({tag, " data ack"}, {7'd0, ack}, 8'd1);
      mdl_write(wbuf[k]);
    end
    i2c_stop();
    check_cfg(tag);
  endtask

  task automatic i2c_read(input int nr, input string tag);
    logic ack;
    logic [7:0] b, e;
    i2c_start();
    i2c_wbyte(I2C_RD, ack); chk8("R2 read address ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < nr; k++) begin
      i2c_rbyte(k != nr - 1, b);
      mdl_read(e);
      chk8(tag, b, e);
    end
    i2c_stop();
  endtask

  // SPI master, clock idles high
  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; sda_m = b[i]; wait_clk(HALF);
      r[i] = sdo; scl = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic spi_write(input logic [7:0] pb, input int nd, input string tag);
    logic [7:0] r;
    cs_n = 1'b0; wait_clk(HALF);
    spi_byte(SPI_WR, r);
    spi_byte(pb, r); mptr = pb[4:0]; mincr = pb[7];
    for (int k = 0; k < nd; k++) begin
      spi_byte(wbuf[k], r); mdl_write(wbuf[k]);
    end
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
    check_cfg(tag);
  endtask

  task automatic spi_read(input int nr, input string tag);
    logic [7:0] r, e;
    cs_n = 1'b0; wait_clk(HALF);
    spi_byte(SPI_RD, r);
    for (int k = 0; k < nr; k++) begin
      spi_byte(8'h00, r); mdl_read(e); chk8(tag, r, e);
    end
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] r;
    int unsigned seed_v;
    seed_v = $urandom(32'd7321);
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    mptr = 5'd0; mincr = 1'b0;
    wait_clk(5); rst_ni = 1'b1; wait_clk(5);

    // R1 reset state
    check_cfg("R1");
    chk8("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    chk8("R1 sdo", {7'd0, sdo}, 8'd0);
    i2c_read(2, "R1 pointer at 00h");

    // R2 wrong slave address
    i2c_start(); i2c_wbyte(I2C_BAD, ack); chk8("R2 wrong address nack", {7'd0, ack}, 8'd0);
    i2c_wbyte(8'h83, ack); i2c_wbyte(8'h5A, ack); i2c_stop();
    check_cfg("R2");

    wbuf[0] = 8'h5A;                                   i2c_write(8'h05, 1, "R3");
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC; i2c_write(8'h03, 3, "R4");
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h10 + 8'(k);
    i2c_write(8'h86, 5, "R5 hold at 08h");
    i2c_write(8'h8F, 4, "R5 hold at 11h");
    i2c_write(8'h81, 10, "R5 first section run");
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    i2c_write(8'h92, 2, "R7 write ignored");
    i2c_read(2, "R7 id read");
    i2c_write(8'h00, 2, "R8 write 00h");
    i2c_write(8'h95, 2, "R8 write 15h");
    i2c_read(2, "R8 reserved read");
    i2c_write(8'h83, 0, "R6"); i2c_read(7, "R6 read run to 08h");
    i2c_write(8'h8E, 0, "R6"); i2c_read(5, "R6 read run to 11h");
    i2c_write(8'h04, 0, "R6"); i2c_read(3, "R6 fixed pointer read");

    for (int t = 0; t < 12; t++) begin
      logic [7:0] pb;
      int nd;
      pb = {1'($urandom % 2), 2'b00, 5'($urandom % 32)};
      nd = int'($urandom % 4);
      for (int k = 0; k < nd; k++) wbuf[k] = 8'($urandom);
      i2c_write(pb, nd, "R3 random");
      i2c_read(1 + int'($urandom % 3), "R6 random");
    end

    // R9 first chip-select fall selects SPI for good
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
    spi_write(8'h87, 4, "R9 first SPI transfer");
    i2c_start(); i2c_wbyte(I2C_WR, ack); chk8("R9 I2C ignored", {7'd0, ack}, 8'd0);
    i2c_wbyte(8'h81, ack); i2c_wbyte(8'h77, ack); i2c_stop();
    check_cfg("R9");

    wbuf[0] = 8'h21; wbuf[1] = 8'h22; spi_write(8'h02, 2, "R10 fixed pointer");
    for (int k = 0; k < 6; k++) wbuf[k] = 8'h30 + 8'(k);
    spi_write(8'h8E, 6, "R10 run to 11h");
    spi_write(8'h81, 0, "R11"); spi_read(10, "R11 read run");
    spi_write(8'h12, 0, "R11"); spi_read(2, "R11 id read");

    cs_n = 1'b0; wait_clk(HALF);
    spi_byte(SPI_BAD, r); spi_byte(8'h81, r); spi_byte(8'hEE, r); spi_byte(8'hEF, r);
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
    check_cfg("R12");
    spi_read(1, "R12 pointer kept");

    for (int t = 0; t < 12; t++) begin
      logic [7:0] pb;
      int nd;
      pb = {1'($urandom % 2), 2'b00, 5'($urandom % 32)};
      nd = int'($urandom % 4);
      for (int k = 0; k < nd; k++) wbuf[k] = 8'($urandom);
      spi_write(pb, nd, "R10 random");
      spi_read(1 + int'($urandom % 3), "R11 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule